// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight interrupt request lines and presents them to a processor through one pending output. A request is recorded when its line rises. A mask can block any line from being signalled. The lowest-numbered unmasked recorded request wins. It raises the pending output only when no interrupt of equal or higher rank is already being serviced.

The processor answers with a one-cycle acknowledge pulse. On the next cycle the controller returns an 8-bit vector, which is a programmable base plus the winning line number. At the same time it moves that line from the recorded set into the in-service set. Software uses a small write port to load the mask, load the vector base and issue end-of-interrupt commands. An end-of-interrupt command either retires the highest-ranked in-service line or retires a named line. If nothing qualifies at acknowledge time, the block returns a fixed spurious vector.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset, `int_pend` and `vec_valid` are 0, every line is masked (mask all ones), the vector base is 0x00, and no request or in-service state is held.
- R2: A request is recorded only on a low-to-high transition of its line, after a two-flop synchronizer. A line that stays high after being acknowledged and retired does not signal again until it falls and rises.
- R3: A line whose mask bit is 1 never causes `int_pend`. Its recorded request is kept, and it is signalled once the mask bit is written to 0.
- R4: Line 0 has the highest rank and line 7 the lowest. The returned vector is the base plus the winning line number, modulo 256.
- R5: `vec_valid` is high for exactly the cycle after an `ack` pulse, with `vec_out` valid in that cycle. A granted acknowledge clears the winner's recorded request and marks it in service.
- R6: `int_pend` is high only while the best unmasked recorded request has a strictly lower line number than every in-service line.
- R7: Writing `wr_sel`=2 with `wr_data[7]`=0 is a non-specific end-of-interrupt. It clears the lowest-numbered in-service line.
- R8: Writing `wr_sel`=2 with `wr_data[7]`=1 is a specific end-of-interrupt. It clears the in-service line numbered `wr_data[2:0]`, and has no effect if that line is not in service.
- R9: An `ack` while `int_pend` is low returns base+7 and changes no in-service state.
- R10: `wr_sel`=0 loads the mask from `wr_data` (bit n masks line n), and `wr_sel`=1 loads the vector base from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 base, 2 end-of-interrupt |
| wr_data | input | 8 | Write data |
| ack | input | 1 | One-cycle acknowledge from the processor |
| int_pend | output | 1 | Interrupt pending to the processor |
| vec_out | output | 8 | Vector returned after acknowledge |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
The hardest state to reach is two nested interrupts in service while a lower-ranked request waits. In that state the pending output depends on the in-service set, which no port shows directly. The stimulus builds this up in steps. It grants a middle-ranked line, then raises a higher-ranked one and grants that too. It then retires the in-service lines one at a time and checks after each that the waiting low-ranked line stays blocked until the last blocker has left.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    // Write port target selector
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_BASE = 2'd1,
        SEL_EOI  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    // Decoded end-of-interrupt command
    typedef struct packed {
        logic       specific;
        logic [6:0] line;
    } eoi_cmd_t;

    function automatic eoi_cmd_t decode_eoi(input logic [7:0] d);
        eoi_cmd_t c;
        c.specific = d[7];
        c.line     = d[6:0];
        return c;
    endfunction

endpackage

// File: rtl/intc_edge_capture.sv
module intc_edge_capture #(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines_in,
    output logic [N_LINES-1:0] rise
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // stages 0..SYNC_STAGES-1 synchronize, the last stage is the delayed copy
        logic [SYNC_STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[SYNC_STAGES-1:0], lines_in[i]};
        end
        assign rise[i] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_LINES-1:0] bits,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // lowest index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [VEC_W-1:0]   wr_data,
    input  logic               ack,
    output logic               int_pend,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_valid
);
    localparam int IDX_W = $clog2(N_LINES);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(N_LINES - 1);

    logic [N_LINES-1:0] irr_q, imr_q, isr_q;
    logic [VEC_W-1:0]   base_q;
    logic [N_LINES-1:0] rise;

    logic               req_found, isr_found;
    logic [IDX_W-1:0]   req_idx, isr_idx;
    logic               grant;
    logic [N_LINES-1:0] grant_oh, eoi_clr;
    eoi_cmd_t           eoi;
    wsel_e              sel;

    intc_edge_capture #(.N_LINES(N_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .lines_in(irq_in), .rise(rise)
    );

    intc_prio_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_req_pick (
        .bits(irr_q & ~imr_q), .found(req_found), .idx(req_idx)
    );

    intc_prio_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_isr_pick (
        .bits(isr_q), .found(isr_found), .idx(isr_idx)
    );

    assign int_pend = req_found && (!isr_found || (req_idx < isr_idx));
    assign grant    = ack && int_pend;
    assign grant_oh = grant ? (N_LINES'(1) << req_idx) : '0;
    assign sel      = wsel_e'(wr_sel);
    assign eoi      = decode_eoi(wr_data[7:0]);

    always_comb begin
        eoi_clr = '0;
        if (wr_en && sel == SEL_EOI) begin
            if (eoi.specific)   eoi_clr = N_LINES'(1) << eoi.line[IDX_W-1:0];
            else if (isr_found) eoi_clr = N_LINES'(1) << isr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q     <= '0;
            imr_q     <= '1;
            isr_q     <= '0;
            base_q    <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            irr_q     <= (irr_q & ~grant_oh) | rise;
            isr_q     <= (isr_q & ~eoi_clr) | grant_oh;
            vec_valid <= ack;
            if (ack)
                vec_out <= base_q + VEC_W'(grant ? req_idx : SPUR_IDX);
            if (wr_en && sel == SEL_MASK) imr_q  <= wr_data[N_LINES-1:0];
            if (wr_en && sel == SEL_BASE) base_q <= wr_data;
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               ack,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic               int_pend,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_out,
    input logic [VEC_W-1:0]   base_q,
    input logic [N_LINES-1:0] irr_q,
    input logic [N_LINES-1:0] imr_q,
    input logic [N_LINES-1:0] isr_q
);
    logic eoi_wr;
    assign eoi_wr = wr_en && (wr_sel == 2'd2);

    assert_vec_valid_R5: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_valid);

    assert_no_stray_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !vec_valid);

    assert_grant_marks_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && int_pend && !eoi_wr) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

    assert_pend_live_R3: assert property (@(posedge clk) disable iff (rst)
        int_pend |-> ((irr_q & ~imr_q) != '0));

    assert_spur_vec_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_pend) |=> (vec_out == $past(base_q) + VEC_W'(N_LINES - 1)));

    assert_spur_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_pend && !eoi_wr) |=> (isr_q == $past(isr_q)));

    assert_eoi_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !ack) |=> ($countones(isr_q) <= $countones($past(isr_q))));
endmodule

bind prio_intc prio_intc_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst(rst), .ack(ack), .wr_en(wr_en), .wr_sel(wr_sel),
    .int_pend(int_pend), .vec_valid(vec_valid), .vec_out(vec_out),
    .base_q(base_q), .irr_q(irr_q), .imr_q(imr_q), .isr_q(isr_q)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       ack;
    logic       int_pend;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack(ack), .int_pend(int_pend), .vec_out(vec_out),
        .vec_valid(vec_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic do_ack(input string tag, input logic [7:0] exp_vec);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk({tag, " vec_valid"}, 32'(vec_valid), 32'd1);
        chk({tag, " vec_out"}, 32'(vec_out), 32'(exp_vec));
        @(negedge clk);
        chk({tag, " vec_valid drops"}, 32'(vec_valid), 32'd0);
    endtask

    task automatic raise(input int line);
        irq_in[line] = 1'b1;
        wait_n(4);
    endtask

    task automatic t_reset;
        chk("R1 pend after reset", 32'(int_pend), 32'd0);
        chk("R1 valid after reset", 32'(vec_valid), 32'd0);
        raise(0);
        chk("R1 reset mask blocks", 32'(int_pend), 32'd0);
        wr(2'd0, 8'h00);
        chk("R3 unmask releases held request", 32'(int_pend), 32'd1);
        do_ack("R1 base resets to zero", 8'h00);
        wr(2'd2, 8'h00);
        irq_in[0] = 1'b0;
        wait_n(4);
    endtask

    task automatic t_basic;
        wr(2'd1, 8'h40);
        raise(5);
        chk("R2 rising edge recorded", 32'(int_pend), 32'd1);
        do_ack("R4 R5 line5 vector", 8'h45);
        chk("R5 request cleared on grant", 32'(int_pend), 32'd0);
        wait_n(6);
        chk("R2 held line no retrigger", 32'(int_pend), 32'd0);
        wr(2'd2, 8'h00);
        chk("R2 held line after eoi", 32'(int_pend), 32'd0);
        irq_in[5] = 1'b0;
        wait_n(4);
        raise(5);
        chk("R2 new edge after fall", 32'(int_pend), 32'd1);
        do_ack("R2 regrant", 8'h45);
        wr(2'd2, 8'h00);
        irq_in[5] = 1'b0;
        wait_n(4);
    endtask

    task automatic t_nested;
        irq_in[6] = 1'b1;
        irq_in[2] = 1'b1;
        wait_n(4);
        do_ack("R4 line2 beats line6", 8'h42);
        chk("R6 lower rank blocked by service", 32'(int_pend), 32'd0);
        raise(1);
        chk("R6 higher rank preempts", 32'(int_pend), 32'd1);
        do_ack("R6 nested grant", 8'h41);
        chk("R6 both in service", 32'(int_pend), 32'd0);
        wr(2'd2, 8'h00);
        chk("R7 nonspecific retires line1 only", 32'(int_pend), 32'd0);
        wr(2'd2, 8'h00);
        chk("R7 second eoi releases line6", 32'(int_pend), 32'd1);
        do_ack("R7 line6 vector", 8'h46);
        wr(2'd2, 8'h00);
        irq_in = '0;
        wait_n(4);
    endtask

    task automatic t_specific;
        raise(3);
        do_ack("R8 line3", 8'h43);
        raise(4);
        chk("R8 line4 blocked", 32'(int_pend), 32'd0);
        wr(2'd2, 8'h84);
        chk("R8 eoi on idle line no effect", 32'(int_pend), 32'd0);
        wr(2'd2, 8'h83);
        chk("R8 specific eoi clears line3", 32'(int_pend), 32'd1);
        do_ack("R8 line4", 8'h44);
        wr(2'd2, 8'h84);
        irq_in = '0;
        wait_n(4);
    endtask

    task automatic t_mask;
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h04);
        raise(2);
        chk("R3 masked line silent", 32'(int_pend), 32'd0);
        raise(6);
        chk("R3 R10 unmasked line signals", 32'(int_pend), 32'd1);
        do_ack("R3 masked higher rank skipped", 8'h86);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        chk("R3 R10 unmask releases line2", 32'(int_pend), 32'd1);
        do_ack("R10 base 0x80 line2", 8'h82);
        wr(2'd2, 8'h00);
        irq_in = '0;
        wait_n(4);
    endtask

    task automatic t_spurious;
        do_ack("R9 spurious vector", 8'h87);
        raise(7);
        chk("R9 no service bit after spurious", 32'(int_pend), 32'd1);
        do_ack("R9 line7 real grant", 8'h87);
        wr(2'd2, 8'h00);
        irq_in = '0;
        wait_n(4);
        wr(2'd1, 8'hFC);
        raise(5);
        do_ack("R4 vector wraps", 8'h01);
        wr(2'd2, 8'h00);
        irq_in = '0;
        wait_n(4);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; ack = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_basic();
        t_nested();
        t_specific();
        t_mask();
        t_spurious();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule